// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block sits beside a small 8-bit processor core and arbitrates three interrupt sources: a USB event, a timer-0 overflow and a timer-1 overflow. Each source delivers a single-cycle pulse. The pulse is latched into a request flag inside an 8-bit control register. Software reads and writes that register through a simple write-enable port. The same register holds a global enable and one enable per source.

The core raises a strobe at every instruction boundary. On that strobe the block decides whether to accept an interrupt. If it accepts one, the next cycle carries a one-cycle acknowledge together with the 13-bit vector address of the winning source. On acceptance the block clears the served flag and the global enable, so the service routine cannot be interrupted.

The core also reports whether its return stack is full, and pulses a strobe for each RET and each RETI. A full stack holds acceptance back. RETI re-arms the global enable and RET does not. A wake output tells the core's HALT logic that an enabled request is waiting.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After the asynchronous active-low reset, every register bit reads 0, ackValid is 0, ackVector is 0 and wake is 0.
- R2: Register layout: bit 0 is the global enable; bits 1, 2 and 3 are the USB, timer-0 and timer-1 enables; bits 4, 5 and 6 are the USB, timer-0 and timer-1 request flags; bit 7 always reads 0. A cycle with regWe high loads bits 0..6 from regWdata, and regRdata shows the new value from the next cycle.
- R3: An event pulse sets its source's flag on the next clock edge, whatever the enables are. A flag stays set until its source is served or software writes the flag bit to 0.
- R4: When an event pulse and a register write fall in the same cycle, the flag of that source ends up 1, whatever value was written.
- R5: Acceptance happens only in a cycle with boundary high, global enable 1, stackFull 0, and at least one source whose enable and flag are both 1. ackValid is then high for exactly the next cycle. ackVector is 0 whenever ackValid is 0.
- R6: When several sources qualify at once, USB wins over timer 0 and timer 0 wins over timer 1. The vectors are 0x004, 0x008 and 0x00C.
- R7: On acceptance, the served flag and the global enable read 0 from the next cycle on, and the other flags are unchanged. If an event of the served source arrives in the same cycle, its flag stays 1.
- R8: While stackFull is 1 at a boundary, nothing is acknowledged and the flags are kept. The request is served at a later boundary where stackFull is 0.
- R9: A retiStb pulse sets the global enable on the next edge, and takes precedence over a register write in the same cycle. An acceptance in the same cycle leaves the global enable at 0. A retStb pulse leaves the global enable unchanged.
- R10: wake is high whenever at least one source has both its enable and its flag at 1, independent of the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| usbEvt | input | 1 | USB event pulse |
| tmr0Evt | input | 1 | Timer-0 overflow pulse |
| tmr1Evt | input | 1 | Timer-1 overflow pulse |
| regWe | input | 1 | Control register write enable |
| regWdata | input | 8 | Control register write data |
| regRdata | output | 8 | Control register read data |
| boundary | input | 1 | Instruction-boundary strobe |
| stackFull | input | 1 | Return stack is full |
| retStb | input | 1 | Plain return executed |
| retiStb | input | 1 | Return-from-interrupt executed |
| ackValid | output | 1 | Interrupt acknowledge, one cycle |
| ackVector | output | 13 | Vector address of the acknowledged source |
| wake | output | 1 | An enabled request is pending |

## Verification
The bench first presents each source on its own with the enables off. This separates flag recording from acceptance. It then presents all three flags pending at once and drains them through RETI. That exposes the priority order and the clearing of the global enable.

Boundary strobes are given with stackFull high and low, and with no strobe at all. These patterns separate holding back a request from dropping it. Same-cycle collisions are driven deliberately, to pin down which update wins in each pair: event against write, event against acknowledge, and RETI against acknowledge. A behavioural model compares the register, the acknowledge and wake on every cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IRQ_SRCS = 3;

  // strobes from the decision logic to the register datapath
  typedef struct packed {
    logic                take;    // an interrupt is accepted this cycle
    logic [IRQ_SRCS-1:0] srcClr;  // served flag to clear
    logic                geSet;   // return-from-interrupt re-arms the global enable
  } irq_strb_t;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int NUM_SRC = IRQ_SRCS,
  parameter int REG_W   = 2 * NUM_SRC + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  irq_strb_t          strb,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               regWe,
  input  logic [REG_W-1:0]   regWdata,
  output logic               geQ,
  output logic [NUM_SRC-1:0] enQ,
  output logic [NUM_SRC-1:0] flagQ,
  output logic [REG_W-1:0]   regRdata
);
  localparam int EN_LSB   = 1;
  localparam int FLAG_LSB = 1 + NUM_SRC;

  // global enable: acceptance beats RETI, RETI beats a write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            geQ <= 1'b0;
    else if (strb.take)   geQ <= 1'b0;
    else if (strb.geSet)  geQ <= 1'b1;
    else if (regWe)       geQ <= regWdata[0];
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)      enQ[i] <= 1'b0;
      else if (regWe) enQ[i] <= regWdata[EN_LSB + i];
    end

    // flag: hardware set beats service clear, which beats a write
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                flagQ[i] <= 1'b0;
      else if (evt[i])          flagQ[i] <= 1'b1;
      else if (strb.srcClr[i])  flagQ[i] <= 1'b0;
      else if (regWe)           flagQ[i] <= regWdata[FLAG_LSB + i];
    end

    p_hw_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
      evt[i] |=> flagQ[i]);
  end

  assign regRdata = REG_W'({flagQ, enQ, geQ});

  p_ge_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |=> !geQ);

  p_reti_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.geSet && !strb.take) |=> geQ);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC  = IRQ_SRCS,
  parameter int VEC_W    = 13,
  parameter int VEC_STEP = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               geQ,
  input  logic [NUM_SRC-1:0] enQ,
  input  logic [NUM_SRC-1:0] flagQ,
  input  logic               boundary,
  input  logic               stackFull,
  input  logic               retiStb,
  output irq_strb_t          strb,
  output logic               ackValid,
  output logic [VEC_W-1:0]   ackVector,
  output logic               wake
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] pending;
  logic [IDX_W-1:0]   selIdx;
  logic               found;
  logic [VEC_W-1:0]   vecNext;

  assign pending = enQ & flagQ;

  // lowest index has the highest priority: scan downwards, last hit wins
  always_comb begin
    found  = 1'b0;
    selIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pending[i]) begin
        found  = 1'b1;
        selIdx = IDX_W'(i);
      end
    end
  end

  assign vecNext = VEC_W'(VEC_STEP) * (VEC_W'(selIdx) + VEC_W'(1));

  always_comb begin
    strb.take   = boundary && !stackFull && geQ && found;
    strb.srcClr = strb.take ? (NUM_SRC'(1) << selIdx) : '0;
    strb.geSet  = retiStb;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackValid  <= 1'b0;
      ackVector <= '0;
    end else begin
      ackValid  <= strb.take;
      ackVector <= strb.take ? vecNext : '0;
    end
  end

  assign wake = |pending;

  p_ack_on_strobe_r5: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> $past(boundary));

  p_single_ack_r5: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |=> !ackValid);

  p_full_block_r8: assert property (@(posedge clk) disable iff (!rstN)
    stackFull |=> !ackValid);

  p_usb_first_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.take && pending[0]) |=> (ackVector == VEC_W'(VEC_STEP)));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int VEC_W    = 13,
  parameter int VEC_STEP = 4,
  parameter int NUM_SRC  = IRQ_SRCS,
  localparam int REG_W   = 2 * NUM_SRC + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             usbEvt,
  input  logic             tmr0Evt,
  input  logic             tmr1Evt,
  input  logic             regWe,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  input  logic             boundary,
  input  logic             stackFull,
  input  logic             retStb,
  input  logic             retiStb,
  output logic             ackValid,
  output logic [VEC_W-1:0] ackVector,
  output logic             wake
);
  irq_strb_t          strb;
  logic               geQ;
  logic [NUM_SRC-1:0] enQ;
  logic [NUM_SRC-1:0] flagQ;
  logic [NUM_SRC-1:0] evt;

  assign evt = NUM_SRC'({tmr1Evt, tmr0Evt, usbEvt});

  irq_regs #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .evt(evt),
    .regWe(regWe), .regWdata(regWdata),
    .geQ(geQ), .enQ(enQ), .flagQ(flagQ), .regRdata(regRdata)
  );

  irq_ctrl #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VEC_STEP(VEC_STEP)) u_ctrl (
    .clk(clk), .rstN(rstN), .geQ(geQ), .enQ(enQ), .flagQ(flagQ),
    .boundary(boundary), .stackFull(stackFull), .retiStb(retiStb),
    .strb(strb), .ackValid(ackValid), .ackVector(ackVector), .wake(wake)
  );

  // plain return leaves the global enable alone
  p_ret_keeps_ge_r9: assert property (@(posedge clk) disable iff (!rstN)
    (retStb && !retiStb && !strb.take && !regWe) |=> $stable(geQ));
endmodule

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
  logic        clk = 0;
  logic        rstN = 0;
  logic        usbEvt = 0, tmr0Evt = 0, tmr1Evt = 0;
  logic        regWe = 0;
  logic [7:0]  regWdata = 0;
  logic [7:0]  regRdata;
  logic        boundary = 0, stackFull = 0, retStb = 0, retiStb = 0;
  logic        ackValid;
  logic [12:0] ackVector;
  logic        wake;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl u0 (
    .clk(clk), .rstN(rstN), .usbEvt(usbEvt), .tmr0Evt(tmr0Evt), .tmr1Evt(tmr1Evt),
    .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .boundary(boundary), .stackFull(stackFull), .retStb(retStb), .retiStb(retiStb),
    .ackValid(ackValid), .ackVector(ackVector), .wake(wake)
  );

  // behavioural reference model
  bit       mGe;
  bit [2:0] mEn, mFlag;
  bit       mAck;
  int       mVec;

  always @(posedge clk or negedge rstN) begin
    int sel;
    bit tk;
    bit ng;
    bit [2:0] nf;
    if (!rstN) begin
      mGe = 0; mEn = 0; mFlag = 0; mAck = 0; mVec = 0;
    end else begin
      sel = -1;
      for (int i = 0; i < 3; i++) if (sel < 0 && mEn[i] && mFlag[i]) sel = i;
      tk = boundary && !stackFull && mGe && (sel >= 0);
      ng = mGe;
      if (regWe) ng = regWdata[0];
      if (retiStb) ng = 1;
      if (tk) ng = 0;
      nf = mFlag;
      if (regWe) nf = regWdata[6:4];
      if (tk) nf[sel] = 0;
      nf = nf | {tmr1Evt, tmr0Evt, usbEvt};
      if (regWe) mEn = regWdata[3:1];
      mGe = ng; mFlag = nf; mAck = tk;
      mVec = tk ? 4 * (sel + 1) : 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rstN) begin
    chk("R2 register", regRdata, {1'b0, mFlag, mEn, mGe});
    chk("R5 ackValid", ackValid, mAck);
    chk("R6 ackVector", ackVector, mVec);
    chk("R10 wake", wake, |(mEn & mFlag));
  end

  task automatic step();
    @(negedge clk);
    usbEvt = 0; tmr0Evt = 0; tmr1Evt = 0; regWe = 0;
    boundary = 0; retStb = 0; retiStb = 0;
  endtask

  task automatic wr(input logic [7:0] v);
    regWe = 1; regWdata = v; step();
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset regs", regRdata, 0);
    chk("R1 reset ack", ackValid, 0);
    chk("R1 reset wake", wake, 0);
    rstN = 1;
    step();

    wr(8'hFF);
    chk("R2 bit7 zero", regRdata, 8'h7F);
    wr(8'h00);
    chk("R2 cleared", regRdata, 8'h00);

    usbEvt = 1; step();
    chk("R3 flag set while disabled", regRdata, 8'h10);
    chk("R10 wake needs enable", wake, 0);
    step();
    chk("R3 flag persists", regRdata, 8'h10);
    wr(8'h12);
    chk("R10 wake enabled", wake, 1);

    regWe = 1; regWdata = 8'h00; tmr0Evt = 1; step();
    chk("R4 hw set beats write", regRdata, 8'h20);

    // all three pending together
    wr(8'h7F);
    boundary = 1; step();
    chk("R6 USB first", ackVector, 13'h004);
    chk("R7 flag and ge cleared", regRdata, 8'h6E);
    step();
    chk("R5 single pulse", ackValid, 0);
    boundary = 1; step();
    chk("R5 no accept ge off", ackValid, 0);
    retStb = 1; step();
    chk("R9 RET keeps ge", regRdata, 8'h6E);
    retiStb = 1; step();
    chk("R9 RETI sets ge", regRdata, 8'h6F);
    boundary = 1; step();
    chk("R6 timer0 second", ackVector, 13'h008);
    chk("R7 timer0 cleared", regRdata, 8'h4E);
    retiStb = 1; step();
    boundary = 1; step();
    chk("R6 timer1 third", ackVector, 13'h00C);
    chk("R7 timer1 cleared", regRdata, 8'h0E);

    // stack full holds the request back
    wr(8'h13);
    stackFull = 1; boundary = 1; step();
    chk("R8 blocked by full stack", ackValid, 0);
    chk("R8 flag kept", regRdata, 8'h13);
    stackFull = 0; step();
    chk("R5 no strobe no accept", ackValid, 0);
    boundary = 1; step();
    chk("R8 served later", ackVector, 13'h004);

    // event collides with acceptance of the same source
    wr(8'h13);
    boundary = 1; usbEvt = 1; step();
    chk("R7 ack with new event", ackValid, 1);
    chk("R7 flag re-set", regRdata, 8'h12);

    // RETI collides with acceptance
    wr(8'h13);
    boundary = 1; retiStb = 1; step();
    chk("R9 ack beats RETI", regRdata, 8'h02);

    // RETI collides with a write
    regWe = 1; regWdata = 8'h00; retiStb = 1; step();
    chk("R9 RETI beats write", regRdata, 8'h01);

    repeat (3) step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule